// File: doc/BRIEF.md
# Configurable Bidirectional Port Controller

This block controls a general-purpose I/O port. A pin-configuration register sets each pin on its own. A simple MCU-style bus with select, write strobe, offset and data reaches a small register file. One register holds the output data. A mode register chooses, for each pin, between that data and an internal address bit. A direction register chooses between input and output. A drive register either turns on open-drain behaviour or, on pins without open-drain support, sets the fast-slew request sent to the pad. An output-enable term from programmable logic can force a pin to drive whatever the direction register holds.

Toward the pads the block provides output data, output enable and slew request for each pin. It takes the pad levels back in through a two-flop synchroniser, and software reads them from a read-only level register. Parameters set the number of pins, the number of low pins that support open-drain, whether the mode register exists, and whether the logic output-enable term is used. With these, a narrow three-pin port without address-out and without a logic term can be built from the same code.

Top module: `port_cfg_ctrl`

## Requirements
- R1: After reset every configuration register (data at offset 0, mode at 1, direction at 2, drive at 3) reads 0x00, and no pin drives unless the logic output-enable term does.
- R2: A bus cycle with select and write high stores the write data into the register at the given offset on that clock edge. A bus cycle with select high and write low returns the stored value on the read-data bus in the same cycle, and the bus reads 0 at any other time or at an unused offset.
- R3: Direction bit n at 1 makes pin n drive (output enable high on a push-pull pin), and at 0 leaves it undriven.
- R4: Mode bit n at 0 sends data-register bit n to pin n. At 1 it sends address-source bit n instead.
- R5: When the logic output-enable term is used, a high term on pin n makes the pin drive even when its direction bit is 0.
- R6: On a pin that supports open-drain (the low OD_PINS pins) with drive bit 1, the pad output is always 0, and the output enable is high only while the pin's source bit is 0 and the pin is driving.
- R7: On a pin that does not support open-drain, the drive bit appears on the fast-slew output and the pin stays push-pull.
- R8: The level register at offset 4 returns the pad inputs through two flops. A change on a pad becomes visible after the second rising clock edge that follows it.
- R9: The level register is read-only. A write to offset 4 changes neither it nor any other register.
- R10: In a narrow variant (PIN_W below the bus width), register bits at and above PIN_W read back as 0. With the logic term disabled, the logic output-enable input has no effect on any pin.
- R11: With the mode register disabled, offset 1 reads 0, ignores writes, and every pin carries its data-register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero outside read cycles |
| addr_src | input | PIN_W | Internal address bits for address-out pins |
| logic_oe | input | PIN_W | Output-enable term from programmable logic |
| pad_in | input | PIN_W | Asynchronous pad levels |
| pad_out | output | PIN_W | Pad output data |
| pad_oe | output | PIN_W | Pad output enable |
| pad_fast_slew | output | PIN_W | Fast-slew request for pins without open-drain |

## Verification
On every cycle the assertions check four things: a pad never drives high while it is in open-drain, a set direction bit or an active logic term always results in a driven push-pull pin, the level register follows the pads two cycles later, and a write to the level offset leaves the configuration alone. Other behaviours appear only in the bench's scenarios: the per-pin choice between data and address, the exact output-enable pattern of open-drain pins against the data value, the zeroed upper bits and ignored logic term of the narrow variant, and the discarded mode writes. The bench compares both a full-width and a narrow instance against its reference model on every cycle.

// File: rtl/port_cfg_pkg.sv
package port_cfg_pkg;

  localparam int unsigned OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_MODE = 3'd1;
  localparam logic [OFS_W-1:0] OFS_DIR  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_DRV  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_LVL  = 3'd4;

  typedef struct packed {
    logic oe;
    logic out;
  } pad_drv_t;

  // A pin wants to drive when its direction bit is set or, if enabled,
  // when the logic term asks for it.
  function automatic logic want_drive(logic dir_bit, logic lg_oe, logic lg_en);
    return dir_bit | (lg_en & lg_oe);
  endfunction

  // Open-drain only pulls low: output fixed at 0, enable only for a 0 source.
  function automatic pad_drv_t pad_drive(logic want, logic od, logic src);
    pad_drv_t r;
    r.out = od ? 1'b0 : src;
    r.oe  = want & (~od | ~src);
    return r;
  endfunction

endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
  import port_cfg_pkg::*;
#(
  parameter int unsigned PIN_W    = 8,
  parameter int unsigned DATA_W   = 8,
  parameter bit          HAS_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PIN_W-1:0]  data_q,
  output logic [PIN_W-1:0]  mode_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  drv_q,
  output logic [3:0]        wr_hit
);

  logic [PIN_W-1:0] wval;
  assign wval = wr_data[PIN_W-1:0];

  assign wr_hit[0] = wr_en && (wr_ofs == OFS_DATA);
  assign wr_hit[1] = wr_en && (wr_ofs == OFS_MODE);
  assign wr_hit[2] = wr_en && (wr_ofs == OFS_DIR);
  assign wr_hit[3] = wr_en && (wr_ofs == OFS_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else begin
      if (wr_hit[0]) data_q <= wval;
      if (wr_hit[2]) dir_q  <= wval;
      if (wr_hit[3]) drv_q  <= wval;
    end
  end

  generate
    if (HAS_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= '0;
        else if (wr_hit[1]) mode_q <= wval;
      end
    end else begin : g_no_mode
      assign mode_q = '0;
    end
  endgenerate

endmodule

// File: rtl/port_in_sync.sv
module port_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/port_pin_slice.sv
module port_pin_slice
  import port_cfg_pkg::*;
#(
  parameter bit OD_OK       = 1'b1,
  parameter bit LOGIC_OE_EN = 1'b1
) (
  input  logic data_bit,
  input  logic mode_bit,
  input  logic addr_bit,
  input  logic dir_bit,
  input  logic drv_bit,
  input  logic lg_oe,
  output logic pad_o,
  output logic pad_oe_o,
  output logic slew_o,
  output logic od_act_o
);

  logic     src;
  pad_drv_t drv;

  assign src      = mode_bit ? addr_bit : data_bit;
  assign od_act_o = OD_OK & drv_bit;
  assign drv      = pad_drive(want_drive(dir_bit, lg_oe, LOGIC_OE_EN), od_act_o, src);
  assign pad_o    = drv.out;
  assign pad_oe_o = drv.oe;
  assign slew_o   = ~OD_OK & drv_bit;

endmodule

// File: rtl/port_cfg_ctrl.sv
module port_cfg_ctrl
  import port_cfg_pkg::*;
#(
  parameter int unsigned PIN_W        = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned OD_PINS      = 4,
  parameter bit          HAS_MODE     = 1'b1,
  parameter bit          HAS_LOGIC_OE = 1'b1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  addr_src,
  input  logic [PIN_W-1:0]  logic_oe,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_fast_slew
);

  logic [PIN_W-1:0] data_q, mode_q, dir_q, drv_q, lvl_q, od_act;
  logic [3:0]       wr_hit;
  logic             rd_cyc;
  logic [PIN_W-1:0] rd_raw;

  port_cfg_regs #(
    .PIN_W   (PIN_W),
    .DATA_W  (DATA_W),
    .HAS_MODE(HAS_MODE)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_sel & bus_wr),
    .wr_ofs (bus_addr),
    .wr_data(bus_wdata),
    .data_q (data_q),
    .mode_q (mode_q),
    .dir_q  (dir_q),
    .drv_q  (drv_q),
    .wr_hit (wr_hit)
  );

  port_in_sync #(
    .W     (PIN_W),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (lvl_q)
  );

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      port_pin_slice #(
        .OD_OK      (i < OD_PINS),
        .LOGIC_OE_EN(HAS_LOGIC_OE)
      ) slice_i (
        .data_bit(data_q[i]),
        .mode_bit(mode_q[i]),
        .addr_bit(addr_src[i]),
        .dir_bit (dir_q[i]),
        .drv_bit (drv_q[i]),
        .lg_oe   (logic_oe[i]),
        .pad_o   (pad_out[i]),
        .pad_oe_o(pad_oe[i]),
        .slew_o  (pad_fast_slew[i]),
        .od_act_o(od_act[i])
      );
    end
  endgenerate

  assign rd_cyc = bus_sel & ~bus_wr;

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_raw = data_q;
      OFS_MODE: rd_raw = mode_q;
      OFS_DIR:  rd_raw = dir_q;
      OFS_DRV:  rd_raw = drv_q;
      OFS_LVL:  rd_raw = lvl_q;
      default:  rd_raw = '0;
    endcase
  end

  assign bus_rdata = rd_cyc ? DATA_W'(rd_raw) : '0;

endmodule

// File: rtl/port_cfg_ctrl_chk.sv
module port_cfg_ctrl_chk
  import port_cfg_pkg::*;
#(
  parameter int unsigned PIN_W        = 8,
  parameter bit          HAS_LOGIC_OE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [PIN_W-1:0] wdata_lo,
  input logic [PIN_W-1:0] logic_oe,
  input logic [PIN_W-1:0] pad_in,
  input logic [PIN_W-1:0] pad_out,
  input logic [PIN_W-1:0] pad_oe,
  input logic [PIN_W-1:0] data_q,
  input logic [PIN_W-1:0] mode_q,
  input logic [PIN_W-1:0] dir_q,
  input logic [PIN_W-1:0] drv_q,
  input logic [PIN_W-1:0] lvl_q,
  input logic [PIN_W-1:0] od_act
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_cnt <= '0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (data_q == '0 && mode_q == '0 && dir_q == '0 && drv_q == '0));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> dir_q == $past(wdata_lo));

  a_r3_dir_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~od_act & ~pad_oe) == '0);

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (od_act & pad_oe & pad_out) == '0);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd2) |-> lvl_q == $past(pad_in, 2));

  a_r9_lvl_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_LVL) |=>
      ($stable(data_q) && $stable(mode_q) && $stable(dir_q) && $stable(drv_q)));

  generate
    if (HAS_LOGIC_OE) begin : g_lg
      a_r5_logic_oe_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_oe & ~od_act & ~pad_oe) == '0);
    end
  endgenerate

endmodule

bind port_cfg_ctrl port_cfg_ctrl_chk #(
  .PIN_W       (PIN_W),
  .HAS_LOGIC_OE(HAS_LOGIC_OE)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[PIN_W-1:0]),
  .logic_oe(logic_oe),
  .pad_in  (pad_in),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .data_q  (data_q),
  .mode_q  (mode_q),
  .dir_q   (dir_q),
  .drv_q   (drv_q),
  .lvl_q   (lvl_q),
  .od_act  (od_act)
);

// File: tb/port_cfg_ctrl_tb_top.sv
module port_cfg_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] addr_src = '0;
  logic [7:0] logic_oe = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] rdata_w, pout_w, poe_w, pslew_w;
  logic [7:0] rdata_n;
  logic [2:0] pout_n, poe_n, pslew_n;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  port_cfg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w),
    .addr_src(addr_src), .logic_oe(logic_oe), .pad_in(pad_in),
    .pad_out(pout_w), .pad_oe(poe_w), .pad_fast_slew(pslew_w)
  );

  port_cfg_ctrl #(
    .PIN_W(3), .OD_PINS(3), .HAS_MODE(1'b0), .HAS_LOGIC_OE(1'b0)
  ) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
    .addr_src(addr_src[2:0]), .logic_oe(logic_oe[2:0]), .pad_in(pad_in[2:0]),
    .pad_out(pout_n), .pad_oe(poe_n), .pad_fast_slew(pslew_n)
  );

  // Reference model: index 0 = full-width port, 1 = narrow port
  int         pw[2]  = '{8, 3};
  bit         hm[2]  = '{1'b1, 1'b0};
  bit         hl[2]  = '{1'b1, 1'b0};
  int         odp[2] = '{4, 3};
  logic [7:0] m_data[2], m_mode[2], m_dir[2], m_drv[2];
  logic [7:0] lvl_hist[$] = '{8'h00, 8'h00};

  function automatic logic [7:0] pmask(int p);
    return 8'((1 << pw[p]) - 1);
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_data[p] = '0; m_mode[p] = '0; m_dir[p] = '0; m_drv[p] = '0;
      end
      lvl_hist = '{8'h00, 8'h00};
    end else begin
      if (bus_sel && bus_wr) begin
        for (int p = 0; p < 2; p++) begin
          case (bus_addr)
            3'd0: m_data[p] = bus_wdata & pmask(p);
            3'd1: if (hm[p]) m_mode[p] = bus_wdata & pmask(p);
            3'd2: m_dir[p] = bus_wdata & pmask(p);
            3'd3: m_drv[p] = bus_wdata & pmask(p);
            default: ;
          endcase
        end
      end
      lvl_hist.push_front(pad_in);
      while (lvl_hist.size() > 2) void'(lvl_hist.pop_back());
    end
  end

  function automatic void exp_pads(int p, output logic [7:0] o, output logic [7:0] e,
                                   output logic [7:0] s);
    o = '0; e = '0; s = '0;
    for (int i = 0; i < pw[p]; i++) begin
      logic src, od, want;
      src  = m_mode[p][i] ? addr_src[i] : m_data[p][i];
      od   = m_drv[p][i] && (i < odp[p]);
      want = m_dir[p][i] || (hl[p] && logic_oe[i]);
      e[i] = want && (!od || !src);
      o[i] = od ? 1'b0 : src;
      s[i] = m_drv[p][i] && (i >= odp[p]);
    end
  endfunction

  function automatic logic [7:0] exp_rd(int p);
    if (!(bus_sel && !bus_wr)) return 8'h00;
    case (bus_addr)
      3'd0: return m_data[p];
      3'd1: return m_mode[p];
      3'd2: return m_dir[p];
      3'd3: return m_drv[p];
      3'd4: return lvl_hist[1] & pmask(p);
      default: return 8'h00;
    endcase
  endfunction

  // Per-cycle comparison, away from both clock edges
  always @(negedge clk) begin
    logic [7:0] eo, ee, es;
    #3;
    exp_pads(0, eo, ee, es);
    check("R4", "wide pad_out", pout_w, eo);
    check("R3", "wide pad_oe", poe_w, ee);
    check("R7", "wide pad_fast_slew", pslew_w, es);
    check("R2", "wide bus_rdata", rdata_w, exp_rd(0));
    exp_pads(1, eo, ee, es);
    check("R4", "narrow pad_out", {5'b0, pout_n}, eo);
    check("R3", "narrow pad_oe", {5'b0, poe_n}, ee);
    check("R7", "narrow pad_fast_slew", {5'b0, pslew_n}, es);
    check("R10", "narrow bus_rdata", rdata_n, exp_rd(1));
  end

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] w, output logic [7:0] n);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #4;
    w = rdata_w; n = rdata_n;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #4;
  endtask

  initial begin
    logic [7:0] w, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd_reg(3'(a), w, n);
      check("R1", "wide reg after reset", w, 8'h00);
      check("R1", "narrow reg after reset", n, 8'h00);
    end
    check("R1", "pad_oe after reset", poe_w, 8'h00);

    // R3/R4: push-pull outputs with MCU data
    wr_reg(3'd0, 8'hA5);
    wr_reg(3'd2, 8'hFF);
    settle();
    check("R3", "all pins driving", poe_w, 8'hFF);
    check("R4", "data on pins", pout_w, 8'hA5);
    rd_reg(3'd2, w, n);
    check("R10", "narrow dir upper bits zero", n, 8'h07);
    check("R2", "dir readback", w, 8'hFF);

    // R4 address-out on upper pins; R11 narrow mode ignored
    addr_src = 8'h3C;
    wr_reg(3'd1, 8'hF0);
    settle();
    check("R4", "mixed data/address pins", pout_w, 8'h35);
    check("R11", "narrow pins carry data", {5'b0, pout_n}, 8'h05);
    rd_reg(3'd1, w, n);
    check("R11", "narrow mode reads zero", n, 8'h00);

    // R5 logic term overrides direction; R10 ignored on narrow
    wr_reg(3'd2, 8'h00);
    logic_oe = 8'h81;
    settle();
    check("R5", "logic term drives", poe_w, 8'h81);
    logic_oe = 8'h07;
    settle();
    check("R10", "narrow ignores logic term", {5'b0, poe_n}, 8'h00);
    logic_oe = 8'h00;

    // R6 open-drain, R7 slew on other pins
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd0, 8'h05);
    wr_reg(3'd2, 8'h0F);
    wr_reg(3'd3, 8'hFF);
    settle();
    check("R6", "open-drain pad_out", pout_w, 8'h00);
    check("R6", "open-drain pad_oe", poe_w, 8'h0A);
    check("R7", "fast slew upper pins", pslew_w, 8'hF0);
    check("R6", "narrow open-drain pad_oe", {5'b0, poe_n}, 8'h02);

    // R8 two-flop sampling of pad levels
    @(negedge clk);
    pad_in = 8'h96; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd4;
    #4 check("R8", "level before any edge", rdata_w, 8'h00);
    @(negedge clk);
    #4 check("R8", "level after one edge", rdata_w, 8'h00);
    @(negedge clk);
    #4 check("R8", "level after two edges", rdata_w, 8'h96);
    check("R8", "narrow level", rdata_n, 8'h06);
    @(negedge clk);
    bus_sel = 1'b0;

    // R9 level register is read-only
    wr_reg(3'd4, 8'hFF);
    rd_reg(3'd4, w, n);
    check("R9", "level unchanged by write", w, 8'h96);
    rd_reg(3'd0, w, n);
    check("R9", "data unchanged by level write", w, 8'h05);

    // Mixed traffic against the reference model
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      bus_sel   = $urandom_range(0, 1);
      bus_wr    = $urandom_range(0, 1);
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom);
      addr_src  = 8'($urandom);
      logic_oe  = 8'($urandom);
      pad_in    = 8'($urandom);
    end
    @(negedge clk);
    bus_sel = 1'b0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule